// File: doc/BRIEF.md
# Two-bit minterm-defined Mealy state machine

This block is a small synchronous sequential circuit. It holds two state bits, A and B, and takes one serial input X. The state bits and the input together form a three-bit index {A,B,X}. A is the most significant bit and X is the least significant bit. Fixed sets of index values decide the next value of each state bit and the value of the output.

Both state bits are stored in D flip-flops that load on the rising clock edge. The output Y is a Mealy output: it is formed combinationally from the present state and the present input, and it is not registered. The state bits are brought out as ports so that a user can observe the sequence the machine walks. A synchronous reset returns the machine to state 00.

Top module: `minterm_fsm`

## Requirements
- R1: When rst is 1 at a rising clock edge, a_q and b_q are both 0 after that edge, whatever the value of x.
- R2: When rst is 0 at a rising edge, a_q after the edge is 1 exactly when the index {a_q,b_q,x} before the edge is 2, 4, 5 or 6. This is equivalent to A·B' + B·X'.
- R3: When rst is 0 at a rising edge, b_q after the edge is 1 exactly when the index {a_q,b_q,x} before the edge is 1, 3, 5 or 6. This is equivalent to A'·X + B'·X + A·B·X'.
- R4: y is 1 exactly when the present index {a_q,b_q,x} is 1 or 5, that is y = B'·X. It is combinational and follows a change of x within the same clock cycle, without waiting for a clock edge.
- R5: a_q and b_q change only at a rising clock edge. A change of x between edges leaves them as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial input X (index bit 0) |
| y | output | 1 | Mealy output, 1 for index 1 or 5 |
| a_q | output | 1 | State bit A (index bit 2) |
| b_q | output | 1 | State bit B (index bit 1) |

## Verification
The clocked assertions take for granted that x and rst are stable and known around each rising edge. They compare the new state with the present-state and input values that `$past` captures at that edge. The bench respects this by changing inputs only on the falling edge, half a period away from the edges where the state loads. Every index is reached by a short, known input path from reset, so no state is forced and the whole table is covered through the normal ports.

// File: rtl/minterm_fsm.sv
module minterm_fsm (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic y,
  output logic a_q,
  output logic b_q
);

  localparam logic [7:0] A_SET = 8'b0111_0100;
  localparam logic [7:0] B_SET = 8'b0110_1010;
  localparam logic [7:0] Y_SET = 8'b0010_0010;

  logic [2:0] idx;
  logic       a_d, b_d;

  assign idx = {a_q, b_q, x};
  assign a_d = A_SET[idx];
  assign b_d = B_SET[idx];
  assign y   = Y_SET[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!a_q && !b_q));

  a_r2_next_a: assert property (@(posedge clk) disable iff (rst)
    !rst |=> a_q == (($past(a_q) & ~$past(b_q)) | ($past(b_q) & ~$past(x))));

  a_r3_next_b: assert property (@(posedge clk) disable iff (rst)
    !rst |=> b_q == ((~$past(a_q) & $past(x)) | (~$past(b_q) & $past(x)) |
                     ($past(a_q) & $past(b_q) & ~$past(x))));

  a_r4_output: assert property (@(posedge clk) disable iff (rst)
    y == (~b_q & x));

endmodule

// File: tb/minterm_fsm_tb.sv
module minterm_fsm_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic y, a_q, b_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // expected {next A, next B, Y} per index {A,B,X}
  localparam logic [2:0] EXP [8] = '{
    3'b000, 3'b011, 3'b100, 3'b010, 3'b100, 3'b111, 3'b110, 3'b000
  };

  minterm_fsm dut_i (.clk(clk), .rst(rst), .x(x), .y(y), .a_q(a_q), .b_q(b_q));

  always #10 clk = ~clk;

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(logic xi);
    @(negedge clk);
    x = xi;
  endtask

  task automatic go_to(logic [1:0] st);
    @(negedge clk); rst = 1'b1; x = 1'b0;
    @(negedge clk); rst = 1'b0;
    case (st)
      2'b01: begin x = 1'b1; @(negedge clk); end
      2'b10: begin x = 1'b1; @(negedge clk); x = 1'b0; @(negedge clk); end
      2'b11: begin x = 1'b1; @(negedge clk); x = 1'b0; @(negedge clk);
                   x = 1'b1; @(negedge clk); end
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R1 reset A", a_q, 1'b0);
    check("R1 reset B", b_q, 1'b0);

    for (int i = 0; i < 8; i++) begin
      logic [2:0] iv;
      iv = 3'(i);
      go_to(iv[2:1]);
      #1;
      check("R2/R3 reach A", a_q, iv[2]);
      check("R2/R3 reach B", b_q, iv[1]);
      x = iv[0];
      #1;
      check("R4 y", y, EXP[i][0]);
      @(negedge clk);
      #1;
      check("R2 next A", a_q, EXP[i][2]);
      check("R3 next B", b_q, EXP[i][1]);
    end

    go_to(2'b11);
    x = 1'b1; rst = 1'b1;
    @(negedge clk); #1;
    check("R1 reset over x A", a_q, 1'b0);
    check("R1 reset over x B", b_q, 1'b0);
    rst = 1'b0;

    go_to(2'b10);
    x = 1'b0; #2;
    check("R4 y mid-cycle low", y, 1'b0);
    x = 1'b1; #2;
    check("R4 y follows x", y, 1'b1);
    check("R5 A stable mid-cycle", a_q, 1'b1);
    check("R5 B stable mid-cycle", b_q, 1'b0);
    x = 1'b0; #2;
    check("R4 y back low", y, 1'b0);
    check("R5 A held", a_q, 1'b1);
    check("R5 B held", b_q, 1'b0);

    go_to(2'b00);
    begin
      logic ea, eb;
      logic [15:0] pat;
      ea = 1'b0; eb = 1'b0;
      pat = 16'b1011_0010_1110_0101;
      for (int k = 0; k < 16; k++) begin
        logic [2:0] ix;
        x = pat[k];
        ix = {ea, eb, pat[k]};
        #1;
        check("R4 y in run", y, EXP[ix][0]);
        ea = EXP[ix][2]; eb = EXP[ix][1];
        @(negedge clk); #1;
        check("R2 A in run", a_q, ea);
        check("R3 B in run", b_q, eb);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule